// File: doc/BRIEF.md
# Clock Replacement Victim Selector

This block chooses which physical frame to evict, using the second-chance (clock) policy. It holds one use bit per frame and a circular victim pointer. Each translation that references a frame reports that frame on the access input, and the block sets the frame's use bit. Software can read any use bit and clear any use bit one at a time.

When a replacement is requested, the block starts a scan at the pointer and examines one frame per clock cycle. A frame whose use bit is set gets that bit cleared and is passed over. The first frame found with a clear bit becomes the victim. The block then raises a one-cycle done pulse with the victim index and leaves the pointer one frame past the victim. The pointer wraps from the last frame to frame 0. It does not move at any time other than during a scan. A scan with no accesses during it takes at most one cycle more than the number of frames, because one full sweep clears every bit.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset, all use bits read 0, the pointer is at frame 0, and `busy_o` and `done_o` are low.
- R2: An access to frame f makes the use bit of f read 1 from the next clock cycle onward.
- R3: A software clear of frame f makes the use bit of f read 0 from the next cycle. If an access to the same frame arrives in the same cycle, the access wins and the bit reads 1.
- R4: A replace request made while idle starts a scan at the pointer. Each frame with its bit set is cleared and skipped, and the first frame with a clear bit is the victim. `busy_o` is high for (skipped frames + 1) cycles. It is followed by a single-cycle `done_o` with `busy_o` low and `victim_o` holding the victim index.
- R5: After a decision the pointer sits at victim+1, and it wraps from frame NUM_FRAMES-1 to frame 0.
- R6: The pointer moves only during a scan. Idle cycles and accesses do not change which frame the next scan starts from.
- R7: With every use bit set, a scan takes NUM_FRAMES+1 busy cycles, selects the frame it started from, and leaves every use bit clear.
- R8: An access in the same cycle in which the scan clears that frame's bit leaves the bit set.
- R9: A replace request made while `busy_o` is high is ignored. It does not start a second scan after the current one completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| acc_valid_i | input | 1 | A translation referenced a frame this cycle |
| acc_frame_i | input | FRAME_W | Index of the referenced frame |
| repl_req_i | input | 1 | Request a victim decision (acted on only when idle) |
| sw_clr_valid_i | input | 1 | Software clear of one use bit |
| sw_clr_frame_i | input | FRAME_W | Frame whose use bit is cleared |
| sw_rd_frame_i | input | FRAME_W | Frame whose use bit is read |
| sw_rd_bit_o | output | 1 | Use bit of the frame selected by `sw_rd_frame_i` |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle pulse marking a decision |
| victim_o | output | FRAME_W | Index of the most recent victim |

## Verification
If the pointer is wrong, the victim of the very next decision shows the wrong index, and the error repeats in every decision after it. If a use bit is wrong, the error shows on the read port one cycle after the access or clear that caused it. During a scan, the same error changes both the busy length and the victim index of that decision. A scan state that does not clear bits as it skips them shows up within one decision: with all bits set, the scan either never ends or takes more than NUM_FRAMES+1 busy cycles.

// File: rtl/clock_victim_pkg.sv
package clock_victim_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_e;
endpackage

// File: rtl/use_bit_array.sv
module use_bit_array #(
  parameter int NUM_FRAMES = 64,
  localparam int FRAME_W = $clog2(NUM_FRAMES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  set_en_i,
  input  logic [FRAME_W-1:0]    set_idx_i,
  input  logic                  scan_clr_en_i,
  input  logic [FRAME_W-1:0]    scan_clr_idx_i,
  input  logic                  sw_clr_en_i,
  input  logic [FRAME_W-1:0]    sw_clr_idx_i,
  output logic [NUM_FRAMES-1:0] use_o
);
  logic [NUM_FRAMES-1:0] use_q, use_d;

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
    logic hit_set, hit_clr;
    always_comb begin
      hit_set = set_en_i && (set_idx_i == FRAME_W'(g));
      hit_clr = (scan_clr_en_i && (scan_clr_idx_i == FRAME_W'(g))) ||
                (sw_clr_en_i   && (sw_clr_idx_i   == FRAME_W'(g)));
      // a set overrides any clear landing in the same cycle
      use_d[g] = hit_set || (use_q[g] && !hit_clr);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) use_q <= '0;
    else         use_q <= use_d;
  end

  assign use_o = use_q;
endmodule

// File: rtl/victim_scan_fsm.sv
module victim_scan_fsm
  import clock_victim_pkg::*;
#(
  parameter int NUM_FRAMES = 64,
  localparam int FRAME_W = $clog2(NUM_FRAMES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               bit_at_ptr_i,
  output logic [FRAME_W-1:0] ptr_o,
  output logic               clr_en_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [FRAME_W-1:0] victim_o
);
  localparam logic [FRAME_W-1:0] LAST = FRAME_W'(NUM_FRAMES - 1);

  scan_state_e        state_q, state_d;
  logic [FRAME_W-1:0] ptr_q, ptr_d, victim_q, victim_d;
  logic               done_q, done_d;
  logic               ptr_en;

  always_comb begin
    state_d  = state_q;
    ptr_d    = ptr_q;
    victim_d = victim_q;
    done_d   = 1'b0;
    clr_en_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) state_d = ST_SCAN;
      ST_SCAN: begin
        ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        if (bit_at_ptr_i) begin
          clr_en_o = 1'b1;
        end else begin
          victim_d = ptr_q;
          done_d   = 1'b1;
          state_d  = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign ptr_en = (state_q == ST_SCAN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ptr_q    <= '0;
      victim_q <= '0;
      done_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (ptr_en) ptr_q    <= ptr_d;
      if (done_d) victim_q <= victim_d;
    end
  end

  assign ptr_o    = ptr_q;
  assign busy_o   = (state_q == ST_SCAN);
  assign done_o   = done_q;
  assign victim_o = victim_q;
endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int NUM_FRAMES = 64,
  localparam int FRAME_W = $clog2(NUM_FRAMES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_valid_i,
  input  logic [FRAME_W-1:0] acc_frame_i,
  input  logic               repl_req_i,
  input  logic               sw_clr_valid_i,
  input  logic [FRAME_W-1:0] sw_clr_frame_i,
  input  logic [FRAME_W-1:0] sw_rd_frame_i,
  output logic               sw_rd_bit_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [FRAME_W-1:0] victim_o
);
  logic [NUM_FRAMES-1:0] use_q;
  logic [FRAME_W-1:0]    ptr_q;
  logic                  scan_clr;

  use_bit_array #(.NUM_FRAMES(NUM_FRAMES)) u_bits (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .set_en_i       (acc_valid_i),
    .set_idx_i      (acc_frame_i),
    .scan_clr_en_i  (scan_clr),
    .scan_clr_idx_i (ptr_q),
    .sw_clr_en_i    (sw_clr_valid_i),
    .sw_clr_idx_i   (sw_clr_frame_i),
    .use_o          (use_q)
  );

  victim_scan_fsm #(.NUM_FRAMES(NUM_FRAMES)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (repl_req_i),
    .bit_at_ptr_i (use_q[ptr_q]),
    .ptr_o        (ptr_q),
    .clr_en_o     (scan_clr),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .victim_o     (victim_o)
  );

  assign sw_rd_bit_o = use_q[sw_rd_frame_i];
endmodule

// File: rtl/clock_victim_sel_chk.sv
module clock_victim_sel_chk #(
  parameter int NUM_FRAMES = 64,
  localparam int FRAME_W = $clog2(NUM_FRAMES)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  acc_valid_i,
  input logic [FRAME_W-1:0]    acc_frame_i,
  input logic                  sw_clr_valid_i,
  input logic [FRAME_W-1:0]    sw_clr_frame_i,
  input logic                  busy_o,
  input logic                  done_o,
  input logic [FRAME_W-1:0]    victim_o,
  input logic [FRAME_W-1:0]    ptr_q,
  input logic [NUM_FRAMES-1:0] use_q
);
  localparam logic [FRAME_W-1:0] LAST = FRAME_W'(NUM_FRAMES - 1);

  assert_access_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |=> use_q[$past(acc_frame_i)]);

  assert_sw_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_clr_valid_i && !(acc_valid_i && acc_frame_i == sw_clr_frame_i))
      |=> !use_q[$past(sw_clr_frame_i)]);

  assert_done_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_after_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  assert_ptr_past_victim_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ptr_q == ((victim_o == LAST) ? '0 : victim_o + 1'b1)));

  assert_ptr_idle_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(ptr_q));
endmodule

bind clock_victim_sel clock_victim_sel_chk #(.NUM_FRAMES(NUM_FRAMES)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .acc_valid_i    (acc_valid_i),
  .acc_frame_i    (acc_frame_i),
  .sw_clr_valid_i (sw_clr_valid_i),
  .sw_clr_frame_i (sw_clr_frame_i),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .victim_o       (victim_o),
  .ptr_q          (ptr_q),
  .use_q          (use_q)
);

// File: tb/clock_victim_sel_tb_top.sv
module clock_victim_sel_tb_top;
  localparam int N = 8;
  localparam int FW = $clog2(N);
  localparam time CLK_PERIOD = 10ns;

  // vector: op[1:0] (0 read,1 access,2 sw clear,3 replace), frame[3:0], exp value[3:0], exp busy[3:0]
  localparam int NV = 14;
  localparam logic [13:0] VEC [NV] = '{
    {2'd0, 4'd3, 4'd0, 4'd0},  // R1 reset: bit clear
    {2'd3, 4'd0, 4'd0, 4'd1},  // replace -> frame 0
    {2'd1, 4'd1, 4'd0, 4'd0},
    {2'd1, 4'd2, 4'd0, 4'd0},
    {2'd3, 4'd0, 4'd3, 4'd3},  // skips 1,2 -> frame 3
    {2'd0, 4'd1, 4'd0, 4'd0},  // cleared by scan
    {2'd1, 4'd5, 4'd0, 4'd0},
    {2'd2, 4'd5, 4'd0, 4'd0},
    {2'd0, 4'd5, 4'd0, 4'd0},  // R3
    {2'd3, 4'd0, 4'd4, 4'd1},
    {2'd3, 4'd0, 4'd5, 4'd1},
    {2'd3, 4'd0, 4'd6, 4'd1},
    {2'd3, 4'd0, 4'd7, 4'd1},
    {2'd3, 4'd0, 4'd0, 4'd1}   // R5 wrap
  };

  logic clk_i = 1'b0;
  logic rst_ni;
  logic acc_valid_i, repl_req_i, sw_clr_valid_i;
  logic [FW-1:0] acc_frame_i, sw_clr_frame_i, sw_rd_frame_i;
  logic sw_rd_bit_o, busy_o, done_o;
  logic [FW-1:0] victim_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  clock_victim_sel #(.NUM_FRAMES(N)) dut_i (.*);

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_access(input int f);
    @(negedge clk_i); acc_valid_i = 1'b1; acc_frame_i = FW'(f);
    @(negedge clk_i); acc_valid_i = 1'b0;
  endtask

  task automatic do_clear(input int f);
    @(negedge clk_i); sw_clr_valid_i = 1'b1; sw_clr_frame_i = FW'(f);
    @(negedge clk_i); sw_clr_valid_i = 1'b0;
  endtask

  task automatic do_read(input string tag, input int f, input int exp);
    @(negedge clk_i); sw_rd_frame_i = FW'(f);
    #1 check(tag, int'(sw_rd_bit_o), exp);
  endtask

  task automatic do_replace(input string tag, input int exp_v, input int exp_b);
    int n = 0;
    int guard = 0;
    @(negedge clk_i); repl_req_i = 1'b1;
    @(negedge clk_i); repl_req_i = 1'b0;
    while (!done_o && guard < 100) begin
      if (busy_o) n++;
      guard++;
      @(negedge clk_i);
    end
    check({tag, " victim"}, int'(victim_o), exp_v);
    check({tag, " busy cycles"}, n, exp_b);
    check({tag, " busy low at done"}, int'(busy_o), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; acc_valid_i = 1'b0; repl_req_i = 1'b0; sw_clr_valid_i = 1'b0;
    acc_frame_i = '0; sw_clr_frame_i = '0; sw_rd_frame_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 busy", int'(busy_o), 0);
    check("R1 done", int'(done_o), 0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      int f, ev, eb;
      op = VEC[i][13:12]; f = int'(VEC[i][11:8]);
      ev = int'(VEC[i][7:4]); eb = int'(VEC[i][3:0]);
      case (op)
        2'd0: do_read("R2 read", f, ev);
        2'd1: do_access(f);
        2'd2: do_clear(f);
        default: do_replace("R4 replace", ev, eb);
      endcase
    end
    // pointer now at frame 1
    do_read("R2 access visible", 0, 0);
    do_access(6);
    do_read("R2 access visible", 6, 1);

    // R3: clear and access on same frame same cycle
    @(negedge clk_i); sw_clr_valid_i = 1'b1; sw_clr_frame_i = 3'd6;
    acc_valid_i = 1'b1; acc_frame_i = 3'd6;
    @(negedge clk_i); sw_clr_valid_i = 1'b0; acc_valid_i = 1'b0;
    do_read("R3 access wins", 6, 1);

    // R7: all bits set, scan from frame 1
    for (int f = 0; f < N; f++) do_access(f);
    do_replace("R7 full sweep", 1, N + 1);
    for (int f = 0; f < N; f++) do_read("R7 all cleared", f, 0);

    // R8: pointer at 2; set frame 2, re-set it as the scan clears it
    do_access(2);
    @(negedge clk_i); repl_req_i = 1'b1;
    @(negedge clk_i); repl_req_i = 1'b0; acc_valid_i = 1'b1; acc_frame_i = 3'd2;
    @(negedge clk_i); acc_valid_i = 1'b0;
    @(negedge clk_i);
    check("R8 done", int'(done_o), 1);
    check("R8 victim", int'(victim_o), 3);
    do_read("R8 set wins", 2, 1);

    // R9/R6: pointer at 4; second request during busy ignored
    @(negedge clk_i); repl_req_i = 1'b1;
    @(negedge clk_i);
    check("R9 busy", int'(busy_o), 1);
    @(negedge clk_i); repl_req_i = 1'b0;
    check("R9 done", int'(done_o), 1);
    check("R9 victim", int'(victim_o), 4);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      check("R9 no second scan", int'(busy_o), 0);
    end
    do_access(7);
    repeat (4) @(negedge clk_i);
    do_replace("R6 pointer held", 5, 1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule